// File: doc/BRIEF.md
# ADC Sample Buffer Writer with Gain Correction and Event Flags

This block sits between an ADC's conversion output and on-chip sample memory. Each signed conversion result is multiplied by a programmable gain in fixed point. A product that exceeds the signed 16-bit range is clamped. When the buffer writer is enabled, the corrected sample goes into a circular region of memory through a one-cycle write port.

The region is defined by a base address and a length held in registers. Software can treat the two halves of the region as alternating ping-pong buffers. One event fires when the first half has just been filled and another when the second half has. The writer then wraps to the base and keeps going.

Four sticky event flags record what happened: a sample was lost because the writer was off, a gain product saturated, the buffer filled, or the first half filled. A mask register selects which flags may raise the single interrupt line. A master enable gates that line, and it is switched on and off by two separate strobe registers. With a zero mask, software polls the flags instead.

Top module: `adc_sample_dma`

## Requirements
- R1: After reset the flags, the mask, the interrupt enable and the writer enable are zero. The gain register holds 1.0 (0x4000), the length register holds 256 and the base register holds 0. `irq` and `mem_we` are low.
- R2: A sample accepted with the writer enabled appears on the write port one cycle later. `mem_addr` is base plus the current index, modulo the memory size. `mem_wdata` is floor(sample × gain / 2^14), where the sample is signed and the gain unsigned. The index then advances.
- R3: A valid sample arriving while the writer is disabled (register 0, bit 0 clear) sets flag bit 0 (overflow). No memory write takes place and the index does not move.
- R4: When the corrected value exceeds 32767 or falls below −32768, the stored value is 0x7FFF or 0x8000 respectively. Flag bit 1 (saturation) also sets. This applies to every valid sample, whether stored or not.
- R5: Writing the sample at index length/2 − 1 (integer division) sets flag bit 3 (half).
- R6: Writing the sample at index length − 1 sets flag bit 2 (full), and the next sample goes to index 0 (the base address).
- R7: Writing register 4 clears each flag whose data bit is 1 and leaves flags whose data bit is 0. If an event sets a flag in the same cycle as its clear, the flag ends up set.
- R8: `irq` is high exactly when the interrupt enable is on and some flag is set whose bit is also set in the mask (register 5, bits 3:0). With a zero mask, `irq` stays low while the flags still update.
- R9: Any write to register 6 turns the interrupt enable on. Any write to register 7 turns it off. Reading either address returns the enable in bit 0.
- R10: Writing the length (register 2) restarts the index at 0. Registers 1 (gain) and 3 (base) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Conversion result valid this cycle |
| smp_data | input | 16 | Signed conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | 12 | Sample memory word address |
| mem_wdata | output | 16 | Corrected sample |
| irq | output | 1 | Interrupt request |

## Verification
The gain path is driven with unity gain and small samples, which shows whether the fixed-point scaling and the floor rounding of negative products are right. Large positive and negative samples at high gain separate the upper clamp from the lower one. Short buffer lengths, both odd and even, are swept so that the half and full indices and the wrap to the base all occur many times. This catches off-by-one errors in either comparison. Random writes to the flag register land on the same cycles as events, and random toggles of the mask, the enable strobes and the writer enable are mixed in. Together these tell set-over-clear priority apart from plain clearing, and overflow apart from normal storage.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  localparam int REG_AW  = 3;
  localparam int N_FLAGS = 4;

  // flag bit positions (software decodes these)
  localparam int FLG_OVF  = 0;
  localparam int FLG_SAT  = 1;
  localparam int FLG_FULL = 2;
  localparam int FLG_HALF = 3;

  localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] OFS_GAIN   = 3'd1;
  localparam logic [REG_AW-1:0] OFS_LEN    = 3'd2;
  localparam logic [REG_AW-1:0] OFS_BASE   = 3'd3;
  localparam logic [REG_AW-1:0] OFS_FLAGS  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_MASK   = 3'd5;
  localparam logic [REG_AW-1:0] OFS_IRQSET = 3'd6;
  localparam logic [REG_AW-1:0] OFS_IRQCLR = 3'd7;
endpackage

// File: rtl/adc_gain_stage.sv
module adc_gain_stage #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic [DATA_W-1:0] smp_in,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] smp_out,
  output logic              sat
);
  localparam int PW = DATA_W + GAIN_W + 1;

  // returns {saturated, clamped result}
  function automatic logic [DATA_W:0] gain_apply(input logic [DATA_W-1:0] s,
                                                 input logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;
    logic signed [PW-1:0] hi;
    logic signed [PW-1:0] lo;
    prod = $signed(s) * $signed({1'b0, g});
    shf  = prod >>> FRAC_W;
    hi   = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    lo   = ~hi;
    if (shf > hi)      return {1'b1, hi[DATA_W-1:0]};
    else if (shf < lo) return {1'b1, lo[DATA_W-1:0]};
    return {1'b0, shf[DATA_W-1:0]};
  endfunction

  logic [DATA_W:0] res;
  assign res     = gain_apply(smp_in, gain);
  assign smp_out = res[DATA_W-1:0];
  assign sat     = res[DATA_W];
endmodule

// File: rtl/adc_ring_ptr.sv
module adc_ring_ptr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [IDX_W:0]   len,
  output logic [IDX_W-1:0] idx,
  output logic             at_half,
  output logic             at_last
);
  localparam int LEN_W = IDX_W + 1;

  logic [LEN_W-1:0] idx_ext;
  logic [LEN_W-1:0] last_pos;
  logic [LEN_W-1:0] half_pos;
  logic             wrap;

  assign idx_ext  = {1'b0, idx};
  assign last_pos = len - LEN_W'(1);
  assign half_pos = (len >> 1) - LEN_W'(1);
  assign at_last  = (idx_ext == last_pos);
  assign at_half  = (idx_ext == half_pos);
  assign wrap     = (idx_ext >= last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (restart) idx <= '0;
    else if (step)    idx <= wrap ? '0 : idx + IDX_W'(1);
  end
endmodule

// File: rtl/adc_event_flags.sv
module adc_event_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  input  logic         irq_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= set_vec[g] | (flags[g] & ~clr_vec[g]);
    end
  end

  assign irq = irq_en & (|(flags & mask));
endmodule

// File: rtl/adc_sample_dma.sv
module adc_sample_dma
  import adc_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 14,
  parameter int IDX_W  = 8,
  parameter int MEM_AW = 12,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq
);
  localparam int LEN_W = IDX_W + 1;
  localparam logic [LEN_W-1:0]  LEN_RST  = LEN_W'(1 << IDX_W);
  localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(1 << FRAC_W);

  // configuration state
  logic              dma_en_q;
  logic [GAIN_W-1:0] gain_q;
  logic [LEN_W-1:0]  len_q;
  logic [MEM_AW-1:0] base_q;
  logic [N_FLAGS-1:0] mask_q;
  logic              irq_en_q;

  // named internal events
  logic              acc_fire;
  logic              ev_ovf;
  logic              ev_sat;
  logic              ev_half;
  logic              ev_full;
  logic              gain_sat;
  logic [DATA_W-1:0] corr_smp;
  logic [IDX_W-1:0]  ring_idx;
  logic              at_half;
  logic              at_last;
  logic [N_FLAGS-1:0] set_vec;
  logic [N_FLAGS-1:0] clr_vec;
  logic [N_FLAGS-1:0] flag_q;

  logic wr_ctrl, wr_gain, wr_len, wr_base, wr_flags, wr_mask, wr_iset, wr_iclr;
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_gain  = reg_wr && (reg_addr == OFS_GAIN);
  assign wr_len   = reg_wr && (reg_addr == OFS_LEN);
  assign wr_base  = reg_wr && (reg_addr == OFS_BASE);
  assign wr_flags = reg_wr && (reg_addr == OFS_FLAGS);
  assign wr_mask  = reg_wr && (reg_addr == OFS_MASK);
  assign wr_iset  = reg_wr && (reg_addr == OFS_IRQSET);
  assign wr_iclr  = reg_wr && (reg_addr == OFS_IRQCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en_q <= 1'b0;
      gain_q   <= GAIN_RST;
      len_q    <= LEN_RST;
      base_q   <= '0;
      mask_q   <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) dma_en_q <= reg_wdata[0];
      if (wr_gain) gain_q   <= reg_wdata[GAIN_W-1:0];
      if (wr_len)  len_q    <= reg_wdata[LEN_W-1:0];
      if (wr_base) base_q   <= reg_wdata[MEM_AW-1:0];
      if (wr_mask) mask_q   <= reg_wdata[N_FLAGS-1:0];
      if (wr_iset)      irq_en_q <= 1'b1;
      else if (wr_iclr) irq_en_q <= 1'b0;
    end
  end

  adc_gain_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_gain (
    .smp_in (smp_data),
    .gain   (gain_q),
    .smp_out(corr_smp),
    .sat    (gain_sat)
  );

  assign acc_fire = smp_valid && dma_en_q;
  assign ev_ovf   = smp_valid && !dma_en_q;
  assign ev_sat   = smp_valid && gain_sat;
  assign ev_half  = acc_fire && at_half;
  assign ev_full  = acc_fire && at_last;

  adc_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (acc_fire),
    .restart(wr_len),
    .len    (len_q),
    .idx    (ring_idx),
    .at_half(at_half),
    .at_last(at_last)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_OVF]  = ev_ovf;
    set_vec[FLG_SAT]  = ev_sat;
    set_vec[FLG_FULL] = ev_full;
    set_vec[FLG_HALF] = ev_half;
  end
  assign clr_vec = wr_flags ? reg_wdata[N_FLAGS-1:0] : '0;

  adc_event_flags #(.N(N_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .mask   (mask_q),
    .irq_en (irq_en_q),
    .flags  (flag_q),
    .irq    (irq)
  );

  // registered memory write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= acc_fire;
      if (acc_fire) begin
        mem_addr  <= base_q + MEM_AW'(ring_idx);
        mem_wdata <= corr_smp;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:   reg_rdata[0]          = dma_en_q;
      OFS_GAIN:   reg_rdata[GAIN_W-1:0] = gain_q;
      OFS_LEN:    reg_rdata[LEN_W-1:0]  = len_q;
      OFS_BASE:   reg_rdata[MEM_AW-1:0] = base_q;
      OFS_FLAGS:  reg_rdata[N_FLAGS-1:0] = flag_q;
      OFS_MASK:   reg_rdata[N_FLAGS-1:0] = mask_q;
      default:    reg_rdata[0]          = irq_en_q;
    endcase
  end
endmodule

// File: rtl/adc_dma_checker.sv
module adc_dma_checker
  import adc_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smp_valid,
  input logic               dma_en_q,
  input logic               acc_fire,
  input logic               ev_sat,
  input logic               ev_half,
  input logic               ev_full,
  input logic [IDX_W-1:0]   ring_idx,
  input logic [N_FLAGS-1:0] flag_q,
  input logic [N_FLAGS-1:0] clr_vec,
  input logic [N_FLAGS-1:0] mask_q,
  input logic               irq_en_q,
  input logic               mem_we,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               irq
);
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  assert_write_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> mem_we);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !dma_en_q) |=> (flag_q[FLG_OVF] && !mem_we));

  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && ev_sat) |=> (mem_wdata == POS_LIM || mem_wdata == NEG_LIM));

  assert_half_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_half |=> flag_q[FLG_HALF]);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> (ring_idx == '0 && flag_q[FLG_FULL]));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec)));

  assert_polled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en_q);
endmodule

bind adc_sample_dma adc_dma_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .dma_en_q (dma_en_q),
  .acc_fire (acc_fire),
  .ev_sat   (ev_sat),
  .ev_half  (ev_half),
  .ev_full  (ev_full),
  .ring_idx (ring_idx),
  .flag_q   (flag_q),
  .clr_vec  (clr_vec),
  .mask_q   (mask_q),
  .irq_en_q (irq_en_q),
  .mem_we   (mem_we),
  .mem_wdata(mem_wdata),
  .irq      (irq)
);

// File: tb/test_adc_sample_dma.sv
`timescale 1ns/1ps
module test_adc_sample_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        irq;

  adc_sample_dma i_adc_sample_dma (.*);

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  int m_flags, m_mask, m_en, m_dma, m_gain, m_len, m_base, m_idx;
  int e_addr, e_data;
  bit e_we;

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int corr_of(input logic [15:0] d, input int g, output bit sat);
    longint p, q;
    p = longint'($signed(d)) * longint'(g);
    q = p >>> 14;
    sat = 1'b0;
    if (q > 32767) begin sat = 1'b1; return 32'h7fff; end
    if (q < -32768) begin sat = 1'b1; return 32'h8000; end
    return int'(q) & 32'hffff;
  endfunction

  task automatic model_reset();
    m_flags = 0; m_mask = 0; m_en = 0; m_dma = 0;
    m_gain = 16384; m_len = 256; m_base = 0; m_idx = 0;
  endtask

  function automatic int rd(input int a);
    return 0;
  endfunction

  task automatic rdreg(input int a, output int v);
    reg_addr = 3'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  // one clock: optional sample and optional register write
  task automatic cyc(input bit v, input logic [15:0] d, input bit w,
                     input int a, input int wd);
    int setv, clrv, c, rv;
    bit sat;
    @(negedge clk);
    smp_valid = v; smp_data = d;
    reg_wr = w; reg_addr = 3'(a); reg_wdata = wd;
    setv = 0; e_we = 1'b0;
    c = corr_of(d, m_gain, sat);
    if (v) begin
      if (sat) setv |= 2;
      if (m_dma == 0) setv |= 1;
      else begin
        e_we = 1'b1; e_data = c; e_addr = (m_base + m_idx) & 12'hfff;
        if (m_idx == m_len / 2 - 1) setv |= 8;
        if (m_idx == m_len - 1) setv |= 4;
        m_idx = (m_idx >= m_len - 1) ? 0 : (m_idx + 1) % 256;
      end
    end
    clrv = (w && a == 4) ? (wd & 15) : 0;
    m_flags = (m_flags & ~clrv) | setv;
    if (w) begin
      case (a)
        0: m_dma = wd & 1;
        1: m_gain = wd & 16'hffff;
        2: begin m_len = wd & 9'h1ff; m_idx = 0; end
        3: m_base = wd & 12'hfff;
        5: m_mask = wd & 15;
        6: m_en = 1;
        7: m_en = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    smp_valid = 1'b0; reg_wr = 1'b0;
    chk("R2 mem_we", mem_we, e_we);
    if (e_we) begin
      chk("R2 mem_addr", mem_addr, e_addr);
      chk("R2 mem_wdata", mem_wdata, e_data);
    end
    chk("R8 irq", irq, (m_en != 0) && ((m_flags & m_mask) != 0));
    rdreg(4, rv);
    chk("R7 flags", rv, m_flags);
  endtask

  task automatic wreg(input int a, input int wd);
    cyc(1'b0, 16'h0, 1'b1, a, wd);
  endtask

  task automatic smp(input logic [15:0] d);
    cyc(1'b1, d, 1'b0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rv;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 mem_we", mem_we, 0);
    rdreg(0, rv); chk("R1 ctrl", rv, 0);
    rdreg(1, rv); chk("R1 gain", rv, 32'h4000);
    rdreg(2, rv); chk("R1 len", rv, 256);
    rdreg(3, rv); chk("R1 base", rv, 0);
    rdreg(4, rv); chk("R1 flags", rv, 0);
    rdreg(5, rv); chk("R1 mask", rv, 0);
    rdreg(6, rv); chk("R1 irq enable", rv, 0);

    // R3 overflow while disabled
    smp(16'h0123);
    chk("R3 no write", mem_we, 0);
    rdreg(4, rv); chk("R3 ovf flag", rv & 1, 1);
    wreg(4, 1);
    rdreg(4, rv); chk("R7 cleared", rv, 0);

    // R10 configuration readback
    wreg(2, 8);
    wreg(3, 12'h100);
    wreg(0, 1);
    rdreg(3, rv); chk("R10 base readback", rv, 12'h100);
    // R2 unity gain, negative floor
    smp(16'd100);
    chk("R2 unity data", mem_wdata, 100);
    chk("R2 base addr", mem_addr, 12'h100);
    wreg(1, 16'h2000);
    rdreg(1, rv); chk("R10 gain readback", rv, 16'h2000);
    smp(16'hfffd);  // -3 * 0.5 = -1.5 -> floor -2
    chk("R2 floor neg", mem_wdata, 16'hfffe);
    smp(16'd7);
    // index 3 is the half point of length 8
    smp(16'd9);
    rdreg(4, rv); chk("R5 half flag", (rv >> 3) & 1, 1);
    chk("R5 half addr", mem_addr, 12'h103);
    // R4 clamps
    wreg(1, 16'hffff);
    smp(16'h7000);
    chk("R4 pos clamp", mem_wdata, 16'h7fff);
    rdreg(4, rv); chk("R4 sat flag", (rv >> 1) & 1, 1);
    smp(16'h9000);
    chk("R4 neg clamp", mem_wdata, 16'h8000);
    wreg(1, 16'h4000);
    smp(16'd1);
    smp(16'd2);  // index 7, last
    rdreg(4, rv); chk("R6 full flag", (rv >> 2) & 1, 1);
    smp(16'd3);
    chk("R6 wrap addr", mem_addr, 12'h100);
    // R7 write zero leaves flags
    rdreg(4, rv);
    wreg(4, 0);
    begin int rv2; rdreg(4, rv2); chk("R7 zero write", rv2, rv); end
    // R7 set wins over clear
    wreg(1, 16'hffff);
    cyc(1'b1, 16'h7000, 1'b1, 4, 15);
    rdreg(4, rv); chk("R7 set wins", rv & 2, 2);
    wreg(1, 16'h4000);
    // R8 / R9
    wreg(6, 0);
    rdreg(6, rv); chk("R9 enable set", rv, 1);
    chk("R8 masked off", irq, 0);
    wreg(5, 15);
    chk("R8 irq on", irq, 1);
    wreg(7, 0);
    rdreg(7, rv); chk("R9 enable clr", rv, 0);
    chk("R9 irq off", irq, 0);
    // R10 length write restarts index
    smp(16'd5);
    wreg(2, 6);
    smp(16'd6);
    chk("R10 restart addr", mem_addr, 12'h100);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit v, w;
      int a, wd;
      v = ($urandom % 4) != 0;
      w = ($urandom % 6) == 0;
      a = $urandom % 8;
      wd = $urandom;
      if (a == 0) wd = (($urandom % 5) != 0) ? 1 : 0;
      if (a == 2) wd = 2 + $urandom % 15;
      if (a == 1 && ($urandom % 2)) wd = 16'h4000;
      cyc(v, 16'($urandom), w, a, wd);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule